// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer for 32-bit virtual addresses. Every entry covers two neighbouring virtual pages, an even one and an odd one, and names a separate physical frame for each. A per-entry page mask widens the page beyond the 4 KB minimum. A global flag lets an entry match under any address-space tag. Each half has its own valid and dirty flags.

Software or a refill engine loads entries through an indexed write port. The load-store path presents a virtual address, the current 8-bit address-space tag and a store flag on the lookup port. One cycle later the block returns a physical address, a writable flag and a 2-bit status. Replacement, read-back and refill sequencing belong to the surrounding logic.

Top module: `tlbp_lookup`

## Requirements
- R1: After reset every entry has all fields zero, so all valid flags are clear. A lookup of an address whose page pair is zero under tag 0 reports invalid (2'b10). Any other address reports miss (2'b01). `res_valid` is low after reset.
- R2: A lookup strobed on `lk_valid` at one rising edge yields its result, with `res_valid` high, after that same edge. `res_valid` is high for exactly one cycle per strobe. In a cycle without a result, status, address and writable are all zero.
- R3: An entry matches when two conditions both hold. The first is that its global flag is set or its stored tag equals `lk_asid`. The second is that its stored page number equals `lk_va`, once the compare-mask bits are cleared in both.
- R4: The compare mask is the entry's page mask ORed with address bits [12:0]. The pair therefore spans at least 8 KB, and each mask bit set above bit 12 doubles the pair. The page mask is expected to be a contiguous run of ones starting at bit 13.
- R5: The highest bit set in the compare mask selects the half. If the address bit at that position is 0, the even frame and flags are used; if it is 1, the odd frame and flags are used.
- R6: If the selected half's valid flag is clear, the status is invalid (2'b10) for both reads and writes.
- R7: A write (`lk_write`=1) to a valid half whose dirty flag is clear reports modify (2'b11), with no translation.
- R8: On match (2'b00), `res_pa` is the half's frame ORed with the address bits below the half-page mask (the compare mask shifted right by one). `res_writable` equals the half's dirty flag, and reads always succeed. For any other status, `res_pa` and `res_writable` are zero.
- R9: When no entry matches, the status is miss (2'b01).
- R10: When several entries match, the lowest index wins.
- R11: A write-port update is visible to lookups strobed at later edges. A lookup strobed at the same edge as the update sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load entry at `wr_idx` |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn | input | 32 | Virtual page-pair number (address form) |
| wr_pmask | input | 32 | Page mask, ones above bit 12 for large pages |
| wr_asid | input | 8 | Address-space tag |
| wr_global | input | 1 | Match under any tag |
| wr_pfn0 | input | 32 | Even-half frame (address form) |
| wr_v0 | input | 1 | Even-half valid |
| wr_d0 | input | 1 | Even-half dirty (writable) |
| wr_pfn1 | input | 32 | Odd-half frame (address form) |
| wr_v1 | input | 1 | Odd-half valid |
| wr_d1 | input | 1 | Odd-half dirty (writable) |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_write | input | 1 | Access is a store |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 00 match, 01 miss, 10 invalid, 11 modify |
| res_pa | output | 32 | Physical address |
| res_writable | output | 1 | Store permitted |

## Verification
Every lookup result is due one edge after its strobe. The bench therefore drives the strobe on a falling edge and reads the outputs at the next falling edge, half a cycle after the register loads. It also checks that the following idle cycle has `res_valid` low and zeroed outputs. Entry loads are checked the same way. A load and a lookup share one edge: the lookup must return the old translation, and the next lookup must return the new one.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    localparam int VA_W   = 32;
    localparam int ASID_W = 8;

    typedef enum logic [1:0] {
        ST_MATCH   = 2'b00,
        ST_MISS    = 2'b01,
        ST_INVALID = 2'b10,
        ST_MODIFY  = 2'b11
    } tlbp_status_e;

    typedef struct packed {
        logic [VA_W-1:0]   vpn;
        logic [VA_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic [VA_W-1:0]   pfn0;
        logic              v0;
        logic              d0;
        logic [VA_W-1:0]   pfn1;
        logic              v1;
        logic              d1;
    } tlbp_entry_t;

    typedef struct packed {
        logic            valid;
        logic [1:0]      status;
        logic [VA_W-1:0] pa;
        logic            writable;
    } tlbp_result_t;
endpackage

// File: rtl/tlbp_entry_store.sv
module tlbp_entry_store
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlbp_entry_t               wr_entry,
    output tlbp_entry_t [ENTRIES-1:0] ents
);
    tlbp_entry_t [ENTRIES-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (wr_en) begin
            ents_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents = ents_q;
endmodule

// File: rtl/tlbp_match.sv
module tlbp_match
    import tlbp_pkg::*;
#(
    parameter int ENTRIES       = 16,
    parameter int MIN_PAGE_BITS = 12,
    localparam logic [VA_W-1:0] LOW_MASK = {VA_W{1'b1}} >> (VA_W - MIN_PAGE_BITS - 1)
) (
    input  tlbp_entry_t [ENTRIES-1:0] ents,
    input  logic [VA_W-1:0]           va,
    input  logic [ASID_W-1:0]         asid,
    output logic [ENTRIES-1:0]        hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [VA_W-1:0] cmask;
        logic            tag_ok;
        logic            page_ok;
        always_comb begin
            cmask   = ents[i].pmask | LOW_MASK;
            tag_ok  = ents[i].glb || (ents[i].asid == asid);
            page_ok = (ents[i].vpn & ~cmask) == (va & ~cmask);
            hit[i]  = tag_ok && page_ok;
        end
    end
endmodule

// File: rtl/tlbp_select.sv
module tlbp_select
    import tlbp_pkg::*;
#(
    parameter int ENTRIES       = 16,
    parameter int MIN_PAGE_BITS = 12,
    localparam int IDX_W        = $clog2(ENTRIES),
    localparam logic [VA_W-1:0] LOW_MASK = {VA_W{1'b1}} >> (VA_W - MIN_PAGE_BITS - 1)
) (
    input  tlbp_entry_t [ENTRIES-1:0] ents,
    input  logic [ENTRIES-1:0]        hit,
    input  logic [VA_W-1:0]           va,
    input  logic                      is_write,
    output logic [1:0]                status,
    output logic [VA_W-1:0]           pa,
    output logic                      writable
);
    logic [IDX_W-1:0] sel;
    logic             found;
    tlbp_entry_t      ent;
    logic [VA_W-1:0]  cmask;
    logic [VA_W-1:0]  half_mask;
    logic             odd;
    logic             h_valid;
    logic             h_dirty;
    logic [VA_W-1:0]  h_pfn;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        ent       = ents[sel];
        cmask     = ent.pmask | LOW_MASK;
        half_mask = cmask >> 1;
        odd       = |(va & cmask & ~half_mask);
        h_valid   = odd ? ent.v1   : ent.v0;
        h_dirty   = odd ? ent.d1   : ent.d0;
        h_pfn     = odd ? ent.pfn1 : ent.pfn0;
        status    = ST_MATCH;
        pa        = '0;
        writable  = 1'b0;
        if (!found) begin
            status = ST_MISS;
        end else if (!h_valid) begin
            status = ST_INVALID;
        end else if (is_write && !h_dirty) begin
            status = ST_MODIFY;
        end else begin
            pa       = h_pfn | (va & half_mask);
            writable = h_dirty;
        end
    end
endmodule

// File: rtl/tlbp_lookup.sv
module tlbp_lookup
    import tlbp_pkg::*;
#(
    parameter int ENTRIES       = 16,
    parameter int MIN_PAGE_BITS = 12,
    localparam int IDX_W        = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_vpn,
    input  logic [VA_W-1:0]   wr_pmask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [VA_W-1:0]   wr_pfn0,
    input  logic              wr_v0,
    input  logic              wr_d0,
    input  logic [VA_W-1:0]   wr_pfn1,
    input  logic              wr_v1,
    input  logic              wr_d1,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [VA_W-1:0]   res_pa,
    output logic              res_writable
);
    tlbp_entry_t               wr_entry;
    tlbp_entry_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]        hit;
    logic [1:0]                c_status;
    logic [VA_W-1:0]           c_pa;
    logic                      c_writable;
    tlbp_result_t              res_d, res_q;

    always_comb begin
        wr_entry = '{vpn: wr_vpn, pmask: wr_pmask, asid: wr_asid, glb: wr_global,
                     pfn0: wr_pfn0, v0: wr_v0, d0: wr_d0,
                     pfn1: wr_pfn1, v1: wr_v1, d1: wr_d1};
    end

    tlbp_entry_store #(.ENTRIES(ENTRIES)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ents     (ents)
    );

    tlbp_match #(.ENTRIES(ENTRIES), .MIN_PAGE_BITS(MIN_PAGE_BITS)) match_i (
        .ents (ents),
        .va   (lk_va),
        .asid (lk_asid),
        .hit  (hit)
    );

    tlbp_select #(.ENTRIES(ENTRIES), .MIN_PAGE_BITS(MIN_PAGE_BITS)) select_i (
        .ents     (ents),
        .hit      (hit),
        .va       (lk_va),
        .is_write (lk_write),
        .status   (c_status),
        .pa       (c_pa),
        .writable (c_writable)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid    = 1'b1;
            res_d.status   = c_status;
            res_d.pa       = c_pa;
            res_d.writable = c_writable;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid    = res_q.valid;
    assign res_status   = res_q.status;
    assign res_pa       = res_q.pa;
    assign res_writable = res_q.writable;
endmodule

// File: rtl/tlbp_lookup_chk.sv
module tlbp_lookup_chk
    import tlbp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_write,
    input logic            res_valid,
    input logic [1:0]      res_status,
    input logic [VA_W-1:0] res_pa,
    input logic            res_writable
);
    p_result_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_no_spurious_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    p_idle_outputs_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_status == 2'b00 && res_pa == '0 && !res_writable));

    p_writable_only_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_writable) |-> (res_status == ST_MATCH));

    p_no_pa_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != ST_MATCH) |-> (res_pa == '0 && !res_writable));

    p_modify_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ST_MODIFY) |-> $past(lk_write));
endmodule

bind tlbp_lookup tlbp_lookup_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_write     (lk_write),
    .res_valid    (res_valid),
    .res_status   (res_status),
    .res_pa       (res_pa),
    .res_writable (res_writable)
);

// File: tb/tlbp_lookup_tb_top.sv
module tlbp_lookup_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 13;

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic        wr;
        logic [1:0]  st;
        logic [31:0] pa;
        logic        wb;
        logic [7:0]  req;
    } vec_t;

    // Entries loaded before the table:
    // 0: pair 0x0040_0000, tag 11, even 0x0010_0000 V D, odd 0x0020_0000 V clean
    // 1: pair 0x0080_0000, 16 KB pages, global, even 0x0300_0000 V D, odd invalid
    // 2: pair 0x00C0_0000, tag 22, even 0x0500_0000, odd 0x0600_0000, both V D
    // 3: same pair and tag as 2, even 0x0700_0000 (must lose to 2)
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0123, 8'h11, 1'b0, 2'b00, 32'h0010_0123, 1'b1, 8'd5},  // R5 even half
        '{32'h0040_1456, 8'h11, 1'b0, 2'b00, 32'h0020_0456, 1'b0, 8'd8},  // R8 read of clean half
        '{32'h0040_1456, 8'h11, 1'b1, 2'b11, 32'h0000_0000, 1'b0, 8'd7},  // R7 modify
        '{32'h0040_0010, 8'h12, 1'b0, 2'b01, 32'h0000_0000, 1'b0, 8'd3},  // R3 tag mismatch
        '{32'h0080_2ABC, 8'h99, 1'b0, 2'b00, 32'h0300_2ABC, 1'b1, 8'd4},  // R4 global, big page
        '{32'h0080_4001, 8'h99, 1'b1, 2'b10, 32'h0000_0000, 1'b0, 8'd6},  // R6 invalid write
        '{32'h0080_4001, 8'h99, 1'b0, 2'b10, 32'h0000_0000, 1'b0, 8'd6},  // R6 invalid read
        '{32'h0080_3FFF, 8'h42, 1'b1, 2'b00, 32'h0300_3FFF, 1'b1, 8'd4},  // R4 top of even half
        '{32'h00C0_0777, 8'h22, 1'b0, 2'b00, 32'h0500_0777, 1'b1, 8'd10}, // R10 lowest index
        '{32'h00C0_1000, 8'h22, 1'b1, 2'b00, 32'h0600_0000, 1'b1, 8'd8},  // R8 dirty store
        '{32'h0000_0ABC, 8'h00, 1'b0, 2'b10, 32'h0000_0000, 1'b0, 8'd1},  // R1 zeroed entry
        '{32'hFFFF_F000, 8'h11, 1'b0, 2'b01, 32'h0000_0000, 1'b0, 8'd9},  // R9 miss
        '{32'h0040_2000, 8'h11, 1'b0, 2'b01, 32'h0000_0000, 1'b0, 8'd9}   // R9 just past pair
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0, wr_v0 = 1'b0, wr_d0 = 1'b0, wr_v1 = 1'b0, wr_d1 = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        res_valid, res_writable;
    logic [1:0]  res_status;
    logic [31:0] res_pa;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tlbp_lookup dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
        .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_d0(wr_d0),
        .wr_pfn1(wr_pfn1), .wr_v1(wr_v1), .wr_d1(wr_d1),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
        .res_valid(res_valid), .res_status(res_status), .res_pa(res_pa),
        .res_writable(res_writable)
    );

    task automatic check_res(input string req, input logic ev, input logic [1:0] est,
                             input logic [31:0] epa, input logic ewb);
        checks++;
        if (res_valid !== ev || res_status !== est || res_pa !== epa || res_writable !== ewb) begin
            errors++;
            $display("FAIL %s: got v=%0b st=%0b pa=%h w=%0b, expected v=%0b st=%0b pa=%h w=%0b",
                     req, res_valid, res_status, res_pa, res_writable, ev, est, epa, ewb);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] vpn, input logic [31:0] pm,
                        input logic [7:0] asid, input logic g,
                        input logic [31:0] p0, input logic v0, input logic d0,
                        input logic [31:0] p1, input logic v1, input logic d1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
        wr_global = g; wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0;
        wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got run still busy, expected done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_res("R1 reset idle", 1'b0, 2'b00, 32'h0, 1'b0);
        look(32'h0000_1234, 8'h00, 1'b0);
        check_res("R1 zero entry invalid", 1'b1, 2'b10, 32'h0, 1'b0);
        look(32'h0040_0000, 8'h11, 1'b0);
        check_res("R1 reset miss", 1'b1, 2'b01, 32'h0, 1'b0);

        load(4'd0, 32'h0040_0000, 32'h0, 8'h11, 1'b0, 32'h0010_0000, 1'b1, 1'b1, 32'h0020_0000, 1'b1, 1'b0);
        load(4'd1, 32'h0080_0000, 32'h0000_6000, 8'h55, 1'b1, 32'h0300_0000, 1'b1, 1'b1, 32'h0400_0000, 1'b0, 1'b0);
        load(4'd2, 32'h00C0_0000, 32'h0, 8'h22, 1'b0, 32'h0500_0000, 1'b1, 1'b1, 32'h0600_0000, 1'b1, 1'b1);
        load(4'd3, 32'h00C0_0000, 32'h0, 8'h22, 1'b0, 32'h0700_0000, 1'b1, 1'b1, 32'h0800_0000, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            look(VECS[i].va, VECS[i].asid, VECS[i].wr);
            check_res($sformatf("R%0d table %0d", VECS[i].req, i), 1'b1, VECS[i].st, VECS[i].pa, VECS[i].wb);
        end

        // R2: one-cycle pulse, quiet outputs in the idle cycle after
        look(32'h0040_0123, 8'h11, 1'b0);
        @(negedge clk);
        check_res("R2 pulse ends", 1'b0, 2'b00, 32'h0, 1'b0);

        // R11: load entry 0 with a new even frame on the same edge as a lookup
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd0; wr_vpn = 32'h0040_0000; wr_pmask = 32'h0; wr_asid = 8'h11;
        wr_global = 1'b0; wr_pfn0 = 32'h0A00_0000; wr_v0 = 1'b1; wr_d0 = 1'b1;
        wr_pfn1 = 32'h0B00_0000; wr_v1 = 1'b1; wr_d1 = 1'b1;
        lk_valid = 1'b1; lk_va = 32'h0040_0123; lk_asid = 8'h11; lk_write = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check_res("R11 same-edge sees old", 1'b1, 2'b00, 32'h0010_0123, 1'b1);
        look(32'h0040_0123, 8'h11, 1'b0);
        check_res("R11 later sees new", 1'b1, 2'b00, 32'h0A00_0123, 1'b1);

        // R3: entry 0 is not global, so a matching tag is required
        look(32'h0040_0123, 8'h10, 1'b0);
        check_res("R3 tag required", 1'b1, 2'b01, 32'h0, 1'b0);

        // R4: 16 KB odd half, offset bits below bit 14 pass through
        load(4'd1, 32'h0080_0000, 32'h0000_6000, 8'h55, 1'b1, 32'h0300_0000, 1'b1, 1'b1, 32'h0400_0000, 1'b1, 1'b0);
        look(32'h0080_7FFF, 8'h01, 1'b0);
        check_res("R4 big odd half", 1'b1, 2'b00, 32'h0400_3FFF, 1'b0);

        done = 1'b1;
        report();
    end
endmodule